// File: doc/BRIEF.md
# Bus Access Violation Capture Unit

This unit collects reports of illegal bus accesses. Each report is a one-cycle pulse that carries a violation index, a slave group number, the master ID, the domain ID, read and write flags, and a 36-bit address. Each report sets a sticky status bit for its index. Those bits drive a single interrupt, and a per-index mask can hold back any of them. Each slave group also records the details of its most recent violation and raises a per-group pending flag.

The details are not visible to software straight away. Software first reads the group pending word and picks a group with a one-hot select. It then runs a start, done and stop handshake on a shift control register. When the copy completes, the stored details of the chosen group sit in two shared debug words. Software reads those, ends the handshake and clears the group's pending flag by writing 1 to it. All access goes through a flat 32-bit register port: one write strobe, a 12-bit byte address, and read data formed combinationally from the address.

Status and mask bits are packed 32 to a word, with words four bytes apart. Index m lives in word m/32 at bit m%32. The index count is a parameter (519 by default), so the last word may be only partly populated. The reset input is asserted asynchronously and released through a two-stage synchronizer, so the block leaves reset two clock edges after rst_n rises.

Top module: `bus_vio_capture`

## Requirements
- R1: After reset, every status bit reads 0 and every used mask bit reads 1. The control word, shift status, shift select, shift control and both debug words read 0, and irq is low.
- R2: A pulse on vio_valid with index m below NUM_IDX sets bit m%32 of the status word at byte offset 0x400 + 4*(m/32). An index at or above NUM_IDX sets no bit.
- R3: Writing a word at a status offset clears exactly the bits written as 1, and bits written as 0 keep their value. When a new violation and a clearing write hit the same bit in the same cycle, the bit ends set.
- R4: Mask words sit at byte offset 4*(m/32) and use the same bit positions as the status words. While the unit is enabled, irq is high exactly when some status bit is set and its mask bit is 0.
- R5: The control word is at 0xF00. Writing it with bit 31 set enables the unit. Writing it with bit 2 set stops the unit, and stop wins if both bits are set. Bit 31 reads back the enable state. While the unit is stopped, irq is held low.
- R6: The group pending word is at 0xF10, with bit g for group g. A violation sets its group's bit and replaces that group's stored details, even if the bit is already set. Writing 1 to a bit clears it.
- R7: The shift control register is at 0xF20. Writing a value with bit 0 set while it reads 0 starts a copy. It then reads 0x1 for SHIFT_LAT (4) clock edges after the write edge and reads 0x3 from then on. Writing a value with bit 0 clear returns it to 0 from any state.
- R8: When the copy completes and the select register holds exactly one set bit g, debug word 0 at 0x900 and debug word 1 at 0x904 take group g's stored details. Debug word 0 holds {4'b0, addr[35:32], read flag, write flag, domain[5:0], master[15:0]}. Debug word 1 holds addr[31:0].
- R9: A copy started with zero or several select bits set still reaches 0x3, but it leaves both debug words unchanged.
- R10: Reads return 0 for unused bits of the last status or mask word, for offsets past the last word, for undecoded or misaligned offsets, and for bit 2 of the control word. Writes to any of these change nothing.
- R11: The shift select register is at 0xF14. It holds the low NUM_GRP bits of the last value written to it and reads them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vio_valid | input | 1 | One-cycle violation report strobe |
| vio_idx | input | IW ($clog2(NUM_IDX)) | Violation index |
| vio_grp | input | GW ($clog2(NUM_GRP)) | Slave group of the violation |
| vio_master | input | 16 | Master ID of the offending access |
| vio_domain | input | 6 | Domain ID of the offending access |
| vio_write | input | 1 | Offending access was a write |
| vio_read | input | 1 | Offending access was a read |
| vio_addr | input | 36 | Offending access address |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Violation interrupt |

## Verification
On every cycle the assertions check several properties. irq is never high while the unit is stopped. The shift control register never shows the unused code 0x2, and it reaches 0x3 only from 0x1. The debug words change only on the edge that completes a copy. A valid report always leaves its status bit and its group pending bit set on the next cycle. The bench scenarios cover what needs a history of register traffic to show. These are the exact bit placement in the first and last words, mask gating of irq, the set-beats-clear collision, and overwriting of a pending group's record. They also cover the exact handshake latency, the debug word layout for read and write violations, the rejected zero and multi-bit selects, and the zero reads and ignored writes at unused locations.

// File: rtl/bvc_pkg.sv
package bvc_pkg;

  localparam int MST_W  = 16;
  localparam int DOM_W  = 6;
  localparam int ADDR_W = 36;

  localparam logic [11:0] OFS_DBG0 = 12'h900;
  localparam logic [11:0] OFS_DBG1 = 12'h904;
  localparam logic [11:0] OFS_CTRL = 12'hF00;
  localparam logic [11:0] OFS_SSTA = 12'hF10;
  localparam logic [11:0] OFS_SSEL = 12'hF14;
  localparam logic [11:0] OFS_SCON = 12'hF20;

  typedef struct packed {
    logic [MST_W-1:0]  mst;
    logic [DOM_W-1:0]  dom;
    logic              wr;
    logic              rd;
    logic [ADDR_W-1:0] addr;
  } vio_rec_t;

  typedef enum logic [1:0] {
    SH_IDLE = 2'b00,
    SH_BUSY = 2'b01,
    SH_DONE = 2'b11
  } shift_st_e;

endpackage

// File: rtl/bvc_status_bank.sv
module bvc_status_bank #(
  parameter int NUM_IDX = 519,
  parameter int IW      = 10,
  parameter int NW      = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vio_valid,
  input  logic [IW-1:0] vio_idx,
  input  logic          mask_we,
  input  logic          stat_we,
  input  logic [7:0]    wsel,
  input  logic [31:0]   wdata,
  output logic [31:0]   rd_mask,
  output logic [31:0]   rd_stat,
  output logic          irq_raw
);

  localparam int SW = (NW > 1) ? $clog2(NW) : 1;

  logic [NUM_IDX-1:0] stat_q, stat_d;
  logic [NUM_IDX-1:0] mask_q, mask_d;
  logic [NW*32-1:0]   stat_pad, mask_pad;
  logic [31:0]        stat_w [NW];
  logic [31:0]        mask_w [NW];

  // per-index next state: a new report beats a clearing write
  for (genvar i = 0; i < NUM_IDX; i++) begin : g_bit
    localparam logic [7:0] WI = 8'(i / 32);
    localparam int         BI = i % 32;
    logic set_i, clr_i, mwr_i;
    assign set_i     = vio_valid && (vio_idx == IW'(i));
    assign clr_i     = stat_we && (wsel == WI) && wdata[BI];
    assign mwr_i     = mask_we && (wsel == WI);
    assign stat_d[i] = set_i | (stat_q[i] & ~clr_i);
    assign mask_d[i] = mwr_i ? wdata[BI] : mask_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    stat_pad = '0;
    mask_pad = '0;
    stat_pad[NUM_IDX-1:0] = stat_q;
    mask_pad[NUM_IDX-1:0] = mask_q;
  end

  for (genvar w = 0; w < NW; w++) begin : g_word
    assign stat_w[w] = stat_pad[w*32 +: 32];
    assign mask_w[w] = mask_pad[w*32 +: 32];
  end

  always_comb begin
    rd_stat = '0;
    rd_mask = '0;
    if (32'(wsel) < NW) begin
      rd_stat = stat_w[wsel[SW-1:0]];
      rd_mask = mask_w[wsel[SW-1:0]];
    end
  end

  assign irq_raw = |(stat_q & ~mask_q);

endmodule

// File: rtl/bvc_group_store.sv
module bvc_group_store
  import bvc_pkg::*;
#(
  parameter int NUM_GRP = 8,
  parameter int GW      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vio_valid,
  input  logic [GW-1:0]      vio_grp,
  input  vio_rec_t           vio_rec,
  input  logic               pend_clr_we,
  input  logic [NUM_GRP-1:0] pend_clr_bits,
  input  logic [NUM_GRP-1:0] sel,
  output logic [NUM_GRP-1:0] pend_q,
  output vio_rec_t           sel_rec
);

  logic [NUM_GRP-1:0] pend_d;
  vio_rec_t           rec_q [NUM_GRP];
  vio_rec_t           rec_d [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic hit;
    assign hit       = vio_valid && (vio_grp == GW'(g));
    assign pend_d[g] = hit | (pend_q[g] & ~(pend_clr_we & pend_clr_bits[g]));
    assign rec_d[g]  = hit ? vio_rec : rec_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rec_q[g] <= '0;
      end else if (hit) begin
        rec_q[g] <= rec_d[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // OR of selected records; only meaningful for a one-hot select
  always_comb begin
    sel_rec = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (sel[g]) sel_rec = sel_rec | rec_q[g];
    end
  end

endmodule

// File: rtl/bvc_shift_ctrl.sv
module bvc_shift_ctrl
  import bvc_pkg::*;
#(
  parameter int NUM_GRP   = 8,
  parameter int SHIFT_LAT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_we,
  input  logic [NUM_GRP-1:0] sel_wdata,
  input  logic               con_we,
  input  logic               con_start,
  input  vio_rec_t           sel_rec,
  output logic [NUM_GRP-1:0] sel_q,
  output shift_st_e          st_q,
  output logic [31:0]        dbg0_q,
  output logic [31:0]        dbg1_q
);

  localparam int CW = (SHIFT_LAT > 1) ? $clog2(SHIFT_LAT) : 1;

  shift_st_e          st_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [NUM_GRP-1:0] sel_d;
  logic [31:0]        dbg0_d, dbg1_d;
  logic               sel_ok, copy_en;

  assign sel_ok = (sel_q != '0) && ((sel_q & (sel_q - 1'b1)) == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (st_q == SH_BUSY) begin
      if (cnt_q == '0) st_d  = SH_DONE;
      else             cnt_d = cnt_q - 1'b1;
    end
    if (con_we) begin
      if (!con_start) begin
        st_d = SH_IDLE;
      end else if (st_q == SH_IDLE) begin
        st_d  = SH_BUSY;
        cnt_d = CW'(SHIFT_LAT - 1);
      end
    end
  end

  assign copy_en = (st_q == SH_BUSY) && (st_d == SH_DONE) && sel_ok;
  assign sel_d   = sel_we ? sel_wdata : sel_q;
  assign dbg0_d  = copy_en ? {4'b0, sel_rec.addr[ADDR_W-1:32], sel_rec.rd, sel_rec.wr,
                              sel_rec.dom, sel_rec.mst} : dbg0_q;
  assign dbg1_d  = copy_en ? sel_rec.addr[31:0] : dbg1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      cnt_q  <= '0;
      sel_q  <= '0;
      dbg0_q <= '0;
      dbg1_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (sel_we)  sel_q  <= sel_d;
      if (copy_en) begin
        dbg0_q <= dbg0_d;
        dbg1_q <= dbg1_d;
      end
    end
  end

endmodule

// File: rtl/bus_vio_capture.sv
module bus_vio_capture
  import bvc_pkg::*;
#(
  parameter  int NUM_IDX   = 519,
  parameter  int NUM_GRP   = 8,
  parameter  int SHIFT_LAT = 4,
  localparam int IW        = (NUM_IDX > 1) ? $clog2(NUM_IDX) : 1,
  localparam int GW        = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vio_valid,
  input  logic [IW-1:0]     vio_idx,
  input  logic [GW-1:0]     vio_grp,
  input  logic [MST_W-1:0]  vio_master,
  input  logic [DOM_W-1:0]  vio_domain,
  input  logic              vio_write,
  input  logic              vio_read,
  input  logic [ADDR_W-1:0] vio_addr,
  input  logic              reg_wr,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);

  localparam int NW = (NUM_IDX + 31) / 32;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // address decode
  logic aligned, mask_hit, stat_hit;
  logic mask_we, stat_we, ctrl_we, ssta_we, ssel_we, scon_we;

  assign aligned  = (reg_addr[1:0] == 2'b00);
  assign mask_hit = aligned && (reg_addr[11:10] == 2'b00) && (32'(reg_addr[9:2]) < NW);
  assign stat_hit = aligned && (reg_addr[11:10] == 2'b01) && (32'(reg_addr[9:2]) < NW);

  always_comb begin
    mask_we = reg_wr && mask_hit;
    stat_we = reg_wr && stat_hit;
    ctrl_we = reg_wr && (reg_addr == OFS_CTRL);
    ssta_we = reg_wr && (reg_addr == OFS_SSTA);
    ssel_we = reg_wr && (reg_addr == OFS_SSEL);
    scon_we = reg_wr && (reg_addr == OFS_SCON);
  end

  // enable state
  logic en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (ctrl_we) begin
      if (reg_wdata[2])       en_d = 1'b0;
      else if (reg_wdata[31]) en_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   en_q <= 1'b0;
    else if (ctrl_we) en_q <= en_d;
  end

  // sub-blocks
  logic [31:0]        rd_mask, rd_stat;
  logic               irq_raw;
  logic [NUM_GRP-1:0] pend_q, sel_q;
  vio_rec_t           vrec, sel_rec;
  shift_st_e          sh_st;
  logic [31:0]        dbg0_q, dbg1_q;

  assign vrec = '{mst: vio_master, dom: vio_domain, wr: vio_write,
                  rd: vio_read, addr: vio_addr};

  bvc_status_bank #(
    .NUM_IDX (NUM_IDX),
    .IW      (IW),
    .NW      (NW)
  ) u_status (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .vio_valid (vio_valid),
    .vio_idx   (vio_idx),
    .mask_we   (mask_we),
    .stat_we   (stat_we),
    .wsel      (reg_addr[9:2]),
    .wdata     (reg_wdata),
    .rd_mask   (rd_mask),
    .rd_stat   (rd_stat),
    .irq_raw   (irq_raw)
  );

  bvc_group_store #(
    .NUM_GRP (NUM_GRP),
    .GW      (GW)
  ) u_groups (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .vio_valid     (vio_valid),
    .vio_grp       (vio_grp),
    .vio_rec       (vrec),
    .pend_clr_we   (ssta_we),
    .pend_clr_bits (reg_wdata[NUM_GRP-1:0]),
    .sel           (sel_q),
    .pend_q        (pend_q),
    .sel_rec       (sel_rec)
  );

  bvc_shift_ctrl #(
    .NUM_GRP   (NUM_GRP),
    .SHIFT_LAT (SHIFT_LAT)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sel_we    (ssel_we),
    .sel_wdata (reg_wdata[NUM_GRP-1:0]),
    .con_we    (scon_we),
    .con_start (reg_wdata[0]),
    .sel_rec   (sel_rec),
    .sel_q     (sel_q),
    .st_q      (sh_st),
    .dbg0_q    (dbg0_q),
    .dbg1_q    (dbg1_q)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (mask_hit)                   reg_rdata = rd_mask;
    else if (stat_hit)              reg_rdata = rd_stat;
    else if (reg_addr == OFS_DBG0)  reg_rdata = dbg0_q;
    else if (reg_addr == OFS_DBG1)  reg_rdata = dbg1_q;
    else if (reg_addr == OFS_CTRL)  reg_rdata = {en_q, 31'b0};
    else if (reg_addr == OFS_SSTA)  reg_rdata = 32'(pend_q);
    else if (reg_addr == OFS_SSEL)  reg_rdata = 32'(sel_q);
    else if (reg_addr == OFS_SCON)  reg_rdata = {30'b0, sh_st};
  end

  assign irq = en_q & irq_raw;

endmodule

// File: rtl/bvc_checks.sv
module bvc_checks #(
  parameter int NUM_IDX = 519,
  parameter int NUM_GRP = 8,
  parameter int IW      = 10,
  parameter int GW      = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vio_valid,
  input logic [IW-1:0]      vio_idx,
  input logic [GW-1:0]      vio_grp,
  input logic               irq,
  input logic               en,
  input logic [1:0]         st,
  input logic [31:0]        dbg0,
  input logic [31:0]        dbg1,
  input logic [NUM_GRP-1:0] pend,
  input logic [NUM_IDX-1:0] stat
);

  a_r5_irq_off_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq);

  a_r7_no_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
    st != 2'b10);

  a_r7_done_only_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'b11 && $past(st) != 2'b11) |-> $past(st) == 2'b01);

  // R8 / R9: debug words move only on the edge that completes a copy
  a_r8_dbg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(st == 2'b11 && $past(st) == 2'b01) |-> ($stable(dbg0) && $stable(dbg1)));

  a_r2_status_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (vio_valid && (32'(vio_idx) < NUM_IDX)) |=> stat[$past(vio_idx)]);

  a_r6_pending_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (vio_valid && (32'(vio_grp) < NUM_GRP)) |=> pend[$past(vio_grp)]);

endmodule

bind bus_vio_capture bvc_checks #(
  .NUM_IDX (NUM_IDX),
  .NUM_GRP (NUM_GRP),
  .IW      (IW),
  .GW      (GW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .vio_valid (vio_valid),
  .vio_idx   (vio_idx),
  .vio_grp   (vio_grp),
  .irq       (irq),
  .en        (en_q),
  .st        (sh_st),
  .dbg0      (dbg0_q),
  .dbg1      (dbg1_q),
  .pend      (pend_q),
  .stat      (u_status.stat_q)
);

// File: tb/bus_vio_capture_tb.sv
module bus_vio_capture_tb;

  localparam int CLK_PERIOD = 10;
  localparam int IW = 10;
  localparam int GW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          vio_valid;
  logic [IW-1:0] vio_idx;
  logic [GW-1:0] vio_grp;
  logic [15:0]   vio_master;
  logic [5:0]    vio_domain;
  logic          vio_write, vio_read;
  logic [35:0]   vio_addr;
  logic          reg_wr;
  logic [11:0]   reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic          irq;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_vio_capture u_dut (
    .clk(clk), .rst_n(rst_n), .vio_valid(vio_valid), .vio_idx(vio_idx),
    .vio_grp(vio_grp), .vio_master(vio_master), .vio_domain(vio_domain),
    .vio_write(vio_write), .vio_read(vio_read), .vio_addr(vio_addr),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic vio(input int idx, input int grp, input logic [15:0] m,
                     input logic [5:0] dm, input logic w, input logic r,
                     input logic [35:0] ad);
    @(negedge clk);
    vio_valid = 1'b1; vio_idx = IW'(idx); vio_grp = GW'(grp);
    vio_master = m; vio_domain = dm; vio_write = w; vio_read = r; vio_addr = ad;
    @(negedge clk);
    vio_valid = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 status word0", 12'h400, 32'h0);
    rd_chk("R1 mask word0", 12'h000, 32'hFFFF_FFFF);
    rd_chk("R1 mask last word", 12'h040, 32'h0000_007F);
    rd_chk("R1 ctrl", 12'hF00, 32'h0);
    rd_chk("R1 shift status", 12'hF10, 32'h0);
    rd_chk("R1 shift select", 12'hF14, 32'h0);
    rd_chk("R1 shift control", 12'hF20, 32'h0);
    rd_chk("R1 dbg0", 12'h900, 32'h0);
    rd_chk("R1 dbg1", 12'h904, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_status_irq;
    vio(37, 0, 16'h0, 6'h0, 1'b0, 1'b1, 36'h0);
    vio(518, 1, 16'h0, 6'h0, 1'b0, 1'b1, 36'h0);
    vio(600, 1, 16'h0, 6'h0, 1'b0, 1'b1, 36'h0);   // out of range index
    rd_chk("R2 word1 bit5", 12'h404, 32'h0000_0020);
    rd_chk("R2 last word bit6", 12'h440, 32'h0000_0040);
    rd_chk("R2 word0 untouched", 12'h400, 32'h0);
    check("R5 irq low while stopped", 32'(irq), 32'h0);
    wr(12'hF00, 32'h8000_0000);
    rd_chk("R5 enable readback", 12'hF00, 32'h8000_0000);
    check("R4 irq masked", 32'(irq), 32'h0);
    wr(12'h004, 32'h0);
    check("R4 irq unmasked", 32'(irq), 32'h1);
    wr(12'h004, 32'h0000_0020);
    check("R4 irq remasked", 32'(irq), 32'h0);
    wr(12'h040, 32'h0);
    check("R4 irq last word", 32'(irq), 32'h1);
    wr(12'hF00, 32'h8000_0004);                    // stop wins over enable
    check("R5 stop forces irq low", 32'(irq), 32'h0);
    rd_chk("R5 ctrl stopped", 12'hF00, 32'h0);
    wr(12'hF00, 32'h8000_0000);
    check("R5 re-enabled irq", 32'(irq), 32'h1);
  endtask

  task automatic t_clear;
    wr(12'h440, 32'h0);
    rd_chk("R3 zero write keeps bit", 12'h440, 32'h0000_0040);
    wr(12'h440, 32'h0000_0040);
    rd_chk("R3 w1c clears", 12'h440, 32'h0);
    check("R4 irq after clear", 32'(irq), 32'h0);
    wr(12'h404, 32'h0000_0020);
    rd_chk("R3 w1c word1", 12'h404, 32'h0);
    // collision: report and clear on the same edge
    @(negedge clk);
    vio_valid = 1'b1; vio_idx = IW'(37); vio_grp = '0;
    reg_wr = 1'b1; reg_addr = 12'h404; reg_wdata = 32'h0000_0020;
    @(negedge clk);
    vio_valid = 1'b0; reg_wr = 1'b0;
    rd_chk("R3 set beats clear", 12'h404, 32'h0000_0020);
    wr(12'h404, 32'hFFFF_FFFF);
    wr(12'hF10, 32'h0000_00FF);
  endtask

  task automatic t_shift;
    logic [31:0] d;
    vio(3, 3, 16'hBEEF, 6'h2A, 1'b1, 1'b0, 36'h9_1234_5678);
    rd_chk("R6 pending g3", 12'hF10, 32'h0000_0008);
    vio(4, 3, 16'h1111, 6'h05, 1'b0, 1'b1, 36'h3_0000_00AB);
    rd_chk("R6 pending stays", 12'hF10, 32'h0000_0008);
    wr(12'hF14, 32'hFFFF_FF08);
    rd_chk("R11 select readback", 12'hF14, 32'h0000_0008);
    wr(12'hF20, 32'h1);
    rd_chk("R7 busy after start", 12'hF20, 32'h1);
    repeat (3) @(negedge clk);
    rd_chk("R7 still busy", 12'hF20, 32'h1);
    rd_chk("R8 dbg0 not yet", 12'h900, 32'h0);
    @(negedge clk);
    rd_chk("R7 done", 12'hF20, 32'h3);
    rd_chk("R8 R6 dbg0 newest record", 12'h900, 32'h0385_1111);
    rd_chk("R8 dbg1 address", 12'h904, 32'h0000_00AB);
    wr(12'hF20, 32'h1);
    rd_chk("R7 start ignored when done", 12'hF20, 32'h3);
    wr(12'hF20, 32'h0);
    rd_chk("R7 stop", 12'hF20, 32'h0);
    wr(12'hF10, 32'h0000_0008);
    rd(12'hF10, d);
    check("R6 w1c pending", d, 32'h0);
  endtask

  task automatic t_bad_sel;
    vio(5, 5, 16'h0042, 6'h3F, 1'b1, 1'b0, 36'hF_8000_0001);
    wr(12'hF14, 32'h0);
    wr(12'hF20, 32'h1);
    repeat (4) @(negedge clk);
    rd_chk("R9 zero select done", 12'hF20, 32'h3);
    rd_chk("R9 zero select dbg0 kept", 12'h900, 32'h0385_1111);
    wr(12'hF20, 32'h0);
    wr(12'hF14, 32'h30);
    wr(12'hF20, 32'h1);
    repeat (4) @(negedge clk);
    rd_chk("R9 multi select done", 12'hF20, 32'h3);
    rd_chk("R9 multi select dbg1 kept", 12'h904, 32'h0000_00AB);
    wr(12'hF20, 32'h0);
    wr(12'hF14, 32'h20);
    wr(12'hF20, 32'h1);
    repeat (4) @(negedge clk);
    rd_chk("R8 write flag dbg0", 12'h900, 32'h0F7F_0042);
    rd_chk("R8 dbg1", 12'h904, 32'h8000_0001);
    wr(12'hF20, 32'h0);
  endtask

  task automatic t_reserved;
    wr(12'h040, 32'hFFFF_FFFF);
    rd_chk("R10 unused mask bits", 12'h040, 32'h0000_007F);
    rd_chk("R10 mask past last word", 12'h044, 32'h0);
    rd_chk("R10 status past last word", 12'h444, 32'h0);
    wr(12'h800, 32'hFFFF_FFFF);
    rd_chk("R10 reserved offset", 12'h800, 32'h0);
    rd_chk("R10 misaligned", 12'h401, 32'h0);
    wr(12'h442, 32'hFFFF_FFFF);              // misaligned: no clear
    vio(512, 0, 16'h0, 6'h0, 1'b0, 1'b1, 36'h0);
    wr(12'h442, 32'hFFFF_FFFF);
    rd_chk("R10 misaligned write ignored", 12'h440, 32'h0000_0001);
    rd_chk("R10 ctrl bit2 reads 0", 12'hF00, 32'h8000_0000);
  endtask

  initial begin
    rst_n = 1'b0; vio_valid = 1'b0; vio_idx = '0; vio_grp = '0;
    vio_master = '0; vio_domain = '0; vio_write = 1'b0; vio_read = 1'b0;
    vio_addr = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_status_irq();
    t_clear();
    t_shift();
    t_bad_sel();
    t_reserved();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule